// File: doc/BRIEF.md
# Four-Pin Either-Edge Interrupt Status Block

This block watches four general-purpose input pins and records every transition on each one, rising or falling, in a byte-wide status register. Software clears a status bit by writing a 1 to its position. A status bit captures edges at all times, whatever the interrupt and mode settings are. The settings only decide whether a recorded edge drives the interrupt output.

The pins form two groups of two. A pin can raise the level interrupt only when four things hold at once: its status bit is set, its interrupt enable is on, either-edge mode is selected for it, and the combined enable of its group is on. A fifth status bit records the standby-supply power-on reset. When the system power-on indication rises while that bit is set, the block issues a one-cycle system control interrupt request. The register is reached through a local strobe with separate read and write qualifiers.

Top module: `edge_irq_status`

## Requirements
- R1: After the battery-backed reset (rst_ni low), the register reads 00h and irq_o and sci_req_o are low. Bits 7:5 always read 0, and writes to them have no effect.
- R2: Any change of level on pin_i[n] sets status bit n (n = 0..3). This holds for both directions. The bit is set at the third rising clock edge after the change is presented, whatever the values of irq_en_i, mode_sel_i and grp_en_i.
- R3: A write (reg_sel_i=1, reg_we_i=1) clears each of status bits 4:0 whose reg_wdata_i bit is 1. A 0 in reg_wdata_i leaves the matching bit unchanged. A set bit holds until it is cleared.
- R4: If an edge sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R5: irq_o is high exactly when some pin n has status bit n, irq_en_i[n], mode_sel_i[n] and the enable of its group all at 1. Pins 0 and 1 use grp_en_i[0], and pins 2 and 3 use grp_en_i[1]. irq_o follows these inputs in the same cycle.
- R6: irq_o is a level. It stays high until software clears the status bit that causes it.
- R7: A high por_evt_i at a clock edge sets status bit 4.
- R8: sci_req_o is high for exactly one cycle, after the clock edge that first samples pwr_on_i high following a low, but only if bit 4 is set. If bit 4 is clear, sci_req_o stays low.
- R9: A read (reg_sel_i=1, reg_we_i=0) loads reg_rdata_o at that clock edge with {3'b000, bit4, status[3:0]}. reg_rdata_o holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous battery-backed reset |
| pin_i | input | 4 | Asynchronous monitored pins |
| mode_sel_i | input | 4 | Per-pin either-edge mode select |
| irq_en_i | input | 4 | Per-pin interrupt enable |
| grp_en_i | input | 2 | Combined enable per pin group |
| por_evt_i | input | 1 | Standby-supply power-on reset event |
| pwr_on_i | input | 1 | System power-on indication |
| reg_sel_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_wdata_i | input | 8 | Write data (1 clears the bit) |
| reg_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Level interrupt |
| sci_req_o | output | 1 | One-cycle system control interrupt request |

## Verification
A pin change presented before clock edge k passes through two synchronizer flops and one edge flop. The status bit therefore sets at edge k+2. The bench drives pins at a falling edge, waits three rising edges, and samples at the next falling edge. irq_o is combinational from status and enables, so it is checked in that same sample window. A read returns data one edge after the strobe. A rising pwr_on_i shows on sci_req_o after the edge that samples it and is gone one edge later. The set-wins case times the clear write to land on edge k+2 exactly.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  parameter int unsigned DEF_NPIN  = 4;
  parameter int unsigned DEF_NGRP  = 2;
  parameter int unsigned DEF_REG_W = 8;

  // pins are split evenly, low pins in group 0
  function automatic int unsigned grp_of(int unsigned pin, int unsigned npin, int unsigned ngrp);
    return pin / (npin / ngrp);
  endfunction
endpackage

// File: rtl/edge_sync_det.sv
module edge_sync_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/edge_status_reg.sv
module edge_status_reg #(
  parameter int unsigned NPIN  = 4,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPIN-1:0]  edge_i,
  input  logic             por_evt_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [NPIN-1:0]  sts_o,
  output logic             por_flag_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int unsigned POR_BIT = NPIN;

  logic [NPIN-1:0]  sts_q;
  logic             por_q;
  logic [NPIN-1:0]  clr_pin;
  logic             clr_por;
  logic [REG_W-1:0] rd_word;
  logic [REG_W-1:0] rdata_q;
  logic             unused_wdata;

  assign clr_pin      = wr_i ? wdata_i[NPIN-1:0] : '0;
  assign clr_por      = wr_i & wdata_i[POR_BIT];
  assign unused_wdata = ^wdata_i[REG_W-1:POR_BIT+1];

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      por_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_pin) | edge_i;
      por_q <= (por_q & ~clr_por) | por_evt_i;
    end
  end

  always_comb begin
    rd_word              = '0;
    rd_word[NPIN-1:0]    = sts_q;
    rd_word[POR_BIT]     = por_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_word;
  end

  assign sts_o      = sts_q;
  assign por_flag_o = por_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/edge_irq_gate.sv
module edge_irq_gate
  import edge_irq_pkg::*;
#(
  parameter int unsigned NPIN = 4,
  parameter int unsigned NGRP = 2
) (
  input  logic [NPIN-1:0] sts_i,
  input  logic [NPIN-1:0] en_i,
  input  logic [NPIN-1:0] mode_i,
  input  logic [NGRP-1:0] grp_en_i,
  output logic            irq_o
);
  logic [NPIN-1:0] hit;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    localparam int unsigned GI = grp_of(g, NPIN, NGRP);
    assign hit[g] = sts_i[g] & en_i[g] & mode_i[g] & grp_en_i[GI];
  end

  assign irq_o = |hit;
endmodule

// File: rtl/sci_pulse_gen.sv
module sci_pulse_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_on_i,
  input  logic flag_i,
  output logic sci_o
);
  logic pwr_q;
  logic sci_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= 1'b0;
      sci_q <= 1'b0;
    end else begin
      pwr_q <= pwr_on_i;
      sci_q <= pwr_on_i & ~pwr_q & flag_i;
    end
  end

  assign sci_o = sci_q;
endmodule

// File: rtl/edge_irq_status.sv
module edge_irq_status
  import edge_irq_pkg::*;
#(
  parameter int unsigned NPIN        = DEF_NPIN,
  parameter int unsigned NGRP        = DEF_NGRP,
  parameter int unsigned REG_W       = DEF_REG_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPIN-1:0]  pin_i,
  input  logic [NPIN-1:0]  mode_sel_i,
  input  logic [NPIN-1:0]  irq_en_i,
  input  logic [NGRP-1:0]  grp_en_i,
  input  logic             por_evt_i,
  input  logic             pwr_on_i,
  input  logic             reg_sel_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             sci_req_o
);
  logic [NPIN-1:0] edge_w;
  logic [NPIN-1:0] sts_w;
  logic            por_flag_w;
  logic            wr_w;
  logic            rd_w;

  assign wr_w = reg_sel_i & reg_we_i;
  assign rd_w = reg_sel_i & ~reg_we_i;

  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    edge_sync_det #(.STAGES(SYNC_STAGES)) u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_i[p]),
      .edge_o(edge_w[p])
    );
  end

  edge_status_reg #(.NPIN(NPIN), .REG_W(REG_W)) u_sts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (edge_w),
    .por_evt_i (por_evt_i),
    .wr_i      (wr_w),
    .rd_i      (rd_w),
    .wdata_i   (reg_wdata_i),
    .sts_o     (sts_w),
    .por_flag_o(por_flag_w),
    .rdata_o   (reg_rdata_o)
  );

  edge_irq_gate #(.NPIN(NPIN), .NGRP(NGRP)) u_gate (
    .sts_i   (sts_w),
    .en_i    (irq_en_i),
    .mode_i  (mode_sel_i),
    .grp_en_i(grp_en_i),
    .irq_o   (irq_o)
  );

  sci_pulse_gen u_sci (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwr_on_i(pwr_on_i),
    .flag_i  (por_flag_w),
    .sci_o   (sci_req_o)
  );
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
  parameter int unsigned NPIN  = 4,
  parameter int unsigned REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPIN-1:0]  edge_w,
  input logic [NPIN-1:0]  sts_w,
  input logic             por_flag_w,
  input logic             wr_w,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic [NPIN-1:0]  irq_en_i,
  input logic             por_evt_i,
  input logic             irq_o,
  input logic             sci_req_o
);
  logic [NPIN-1:0] clr_m;
  assign clr_m = wr_w ? reg_wdata_i[NPIN-1:0] : '0;

  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:NPIN+1] == '0);

  a_r2_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_w != '0) |=> ((sts_w & $past(edge_w)) == $past(edge_w)));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_w != '0) |=> (($past(sts_w) & ~$past(clr_m) & ~sts_w) == '0));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_w & clr_m) != '0) |=> ((sts_w & $past(edge_w & clr_m)) == $past(edge_w & clr_m)));

  a_r5_irq_needs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((sts_w & irq_en_i) != '0));

  a_r7_por_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_evt_i |=> por_flag_w);

  a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_req_o |=> !sci_req_o);

  a_r8_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_req_o |-> $past(por_flag_w));
endmodule

bind edge_irq_status edge_irq_chk #(.NPIN(NPIN), .REG_W(REG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .edge_w     (edge_w),
  .sts_w      (sts_w),
  .por_flag_w (por_flag_w),
  .wr_w       (wr_w),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_en_i   (irq_en_i),
  .por_evt_i  (por_evt_i),
  .irq_o      (irq_o),
  .sci_req_o  (sci_req_o)
);

// File: tb/sim_edge_irq_status.sv
`timescale 1ns/1ps
module sim_edge_irq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = '0, mode = '0, en = '0;
  logic [1:0] grp = '0;
  logic       por_evt = 1'b0, pwr_on = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, sci;

  int n_chk = 0;
  int n_err = 0;
  logic [4:0] exp_st = '0;

  always #4 clk = ~clk;

  edge_irq_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .mode_sel_i(mode),
    .irq_en_i(en), .grp_en_i(grp), .por_evt_i(por_evt), .pwr_on_i(pwr_on),
    .reg_sel_i(sel), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .sci_req_o(sci)
  );

  function automatic logic model_irq(logic [4:0] st, logic [3:0] e, logic [3:0] m, logic [1:0] g);
    logic r = 1'b0;
    for (int i = 0; i < 4; i++) r |= st[i] & e[i] & m[i] & g[i/2];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  task automatic reg_wr(logic [7:0] v);
    @(negedge clk); sel = 1'b1; we = 1'b1; wdata = v;
    @(posedge clk);
    @(negedge clk); sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(output logic [7:0] v);
    @(negedge clk); sel = 1'b1; we = 1'b0;
    @(posedge clk);
    @(negedge clk); sel = 1'b0;
    v = rdata;
  endtask

  // drive pins, wait until the edge has reached status (3 edges), sample at negedge
  task automatic set_pins(logic [3:0] p);
    @(negedge clk); pins = p;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [3:0] np;
    logic [7:0] m;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 sci", sci, 0);
    reg_rd(v); chk("R1 read", v, 8'h00);

    // R2 rising edge with everything disabled, R5 no irq
    set_pins(4'b0001);
    reg_rd(v); chk("R2 rise", v, 8'h01);
    chk("R5 disabled", irq, 0);
    // R3 clear, then R2 falling edge
    reg_wr(8'h01); reg_rd(v); chk("R3 clear", v, 8'h00);
    set_pins(4'b0000);
    reg_rd(v); chk("R2 fall", v, 8'h01);
    // R3 write 0 no effect, R1 reserved write ignored
    reg_wr(8'hE0); reg_rd(v); chk("R3 zero write", v, 8'h01);
    chk("R1 reserved", v[7:5], 0);

    // R5 gating
    @(negedge clk); en = 4'b0001; mode = 4'b0001; grp = 2'b01;
    #1 chk("R5 all on", irq, 1);
    grp = 2'b10; #1 chk("R5 group off", irq, 0);
    grp = 2'b01; mode = 4'b0000; #1 chk("R5 mode off", irq, 0);
    mode = 4'b0001;
    // R6 stays asserted
    repeat (5) @(posedge clk);
    @(negedge clk); chk("R6 level", irq, 1);
    reg_wr(8'h01); chk("R6 cleared", irq, 0);
    // pin 2 in group 1
    set_pins(4'b0100);
    @(negedge clk); en = 4'b0100; mode = 4'b0100; grp = 2'b01;
    #1 chk("R5 pin2 grp0 only", irq, 0);
    grp = 2'b10; #1 chk("R5 pin2 grp1", irq, 1);
    reg_wr(8'h04);

    // R4 edge coincides with clear: pin change before edge k, clear at edge k+2
    @(negedge clk); pins = 4'b1100;
    @(posedge clk); @(posedge clk);
    @(negedge clk); sel = 1'b1; we = 1'b1; wdata = 8'h08;
    @(posedge clk);
    @(negedge clk); sel = 1'b0; we = 1'b0; wdata = '0;
    reg_rd(v); chk("R4 set wins", v, 8'h08);
    reg_wr(8'h0F);
    reg_rd(v); chk("R9 read after clear", v, 8'h00);

    // R7 power-on flag, R8 pulse
    @(negedge clk); por_evt = 1'b1;
    @(negedge clk); por_evt = 1'b0;
    reg_rd(v); chk("R7 por flag", v, 8'h10);
    @(negedge clk); pwr_on = 1'b1;
    @(negedge clk); chk("R8 pulse", sci, 1);
    @(negedge clk); chk("R8 one cycle", sci, 0);
    reg_wr(8'h10); reg_rd(v); chk("R7 clear", v, 8'h00);
    @(negedge clk); pwr_on = 1'b0;
    @(negedge clk); pwr_on = 1'b1;
    @(negedge clk); chk("R8 no flag", sci, 0);
    @(negedge clk); pwr_on = 1'b0;

    // random phase
    exp_st = '0;
    for (int s = 0; s < 400; s++) begin
      np = 4'($urandom);
      @(negedge clk);
      en = 4'($urandom); mode = 4'($urandom); grp = 2'($urandom);
      exp_st[3:0] |= np ^ pins;
      set_pins(np);
      chk("R5 random irq", irq, model_irq(exp_st, en, mode, grp));
      if ($urandom % 2 == 0) begin
        m = 8'($urandom);
        reg_wr(m);
        exp_st &= ~m[4:0];
      end
      reg_rd(v); chk("R9 random read", v, {3'b000, exp_st});
    end
    finish_run();
  end
endmodule